// File: doc/BRIEF.md
# Multi-Mode Level-One Memory with Self-Test Preload

This block is a level-one memory array that one core reads for instructions or data. A mode register selects what the array is used as. It can be a small direct-mapped cache with tags and a refill path toward the next memory level. It can be a plainly addressed scratchpad that a debug port can write. It can also be a self-test store that holds a fixed liveness program.

The block leaves reset in self-test mode, and its rows already hold that program, so a core can start fetching at once. When the core runs one of the program's toggle words, it flips an external pin. Software later moves the block into scratchpad or cache mode by writing the mode register.

All addresses are word addresses, and one word is eight bytes. In cache mode the low five bits of an address pick the row and the upper bits form the tag. Reads take one cycle in every mode. A cache miss raises one refill request and holds it until the fill arrives, and the core then repeats its read.

Top module: `l1_multimode_mem`

## Requirements
- R1: After reset the block is in self-test mode, coreValid and missReq are 0, and reads return the preloaded program.
- R2: The program fills rows 0 to 31. The opcode is in bits [63:56]. Rows 4, 12 and 20 hold a toggle word (0x7E, all other bits zero). Row 27 holds a jump word (0x6A) whose bits [15:0] are 0x0040, the byte offset of row 8. Rows 5, 6, 7 and 28 to 31 are all zero (no-op). Every other row holds opcode 0x11 with the row's byte offset (row times 8) in bits [15:0].
- R3: A mode write with modeWrEn selects the mode: code 0 is cache, 1 is scratchpad and 2 is self-test. A write of code 3 has no effect.
- R4: A read accepted in cycle t gives coreValid=1 and its data in cycle t+1. In scratchpad and self-test modes coreHit is always 1.
- R5: In scratchpad mode a debug write stores dbgWrData in row dbgRow. A core read returns the contents of row coreAddr[4:0], whatever the upper address bits are. Debug writes in cache and self-test modes change nothing.
- R6: In cache mode a read hits only when its row is valid and the stored tag equals coreAddr[12:5]. A hit returns that row's data.
- R7: A cache miss drives missReq=1 in the next cycle, with missAddr equal to the missed word address. Both hold until fillValid. A read made while the miss is pending gets no coreValid.
- R8: A fill writes fillData and the captured tag into the captured row and marks the row valid. missReq falls in the next cycle, and the next read of that address hits and returns fillData.
- R9: An accepted mode write clears every valid bit and cancels any pending miss. A read in the same cycle as that write is dropped.
- R10: Entering self-test mode writes the program back into every row, over any data stored there before.
- R11: fillValid while no miss is pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWrEn | input | 1 | Mode register write strobe |
| modeWrData | input | 2 | New mode code |
| coreReq | input | 1 | Core read request |
| coreAddr | input | WORD_ADDR_W (13) | Core word address |
| coreValid | output | 1 | Read result valid |
| coreHit | output | 1 | Read hit (forced 1 outside cache mode) |
| coreRdata | output | DATA_W (64) | Read data |
| dbgWrEn | input | 1 | Debug write strobe |
| dbgRow | input | log2(ROWS) (5) | Debug write row |
| dbgWrData | input | DATA_W (64) | Debug write data |
| missReq | output | 1 | Refill request |
| missAddr | output | WORD_ADDR_W (13) | Word address being refilled |
| fillValid | input | 1 | Refill data valid |
| fillData | input | DATA_W (64) | Refill data |

## Verification
The hardest state to reach is a pending miss that is still open when something else happens. That something can be a second read, a new mode write, or a fill that arrives with nothing pending. It is hard because the miss must first be provoked, and then a different event must arrive before the fill. The directed part of the bench opens a miss on purpose and follows it with each of those events. The random part keeps addresses within four tags so that hits, conflict misses, reloads and mode switches all follow one another often.

// File: rtl/l1mm_pkg.sv
package l1mm_pkg;

  typedef enum logic [1:0] {
    MODE_CACHE    = 2'd0,
    MODE_SCRATCH  = 2'd1,
    MODE_SELFTEST = 2'd2
  } memMode_e;

  localparam logic [1:0] MODE_RSVD = 2'd3;

  localparam logic [7:0] OP_NOP    = 8'h00;
  localparam logic [7:0] OP_ALU    = 8'h11;
  localparam logic [7:0] OP_TOGGLE = 8'h7E;
  localparam logic [7:0] OP_JUMP   = 8'h6A;
  localparam int unsigned PROG_ROWS = 32;

  // Strobes from control to datapath
  typedef struct packed {
    logic rdEn;
    logic forceHit;
    logic missCapture;
    logic fillWr;
    logic dbgWr;
    logic clearValid;
    logic loadProg;
  } ctrlStrobe_t;

  // Liveness program word for a row (R2)
  function automatic logic [63:0] progWord(input int unsigned row);
    logic [63:0] w;
    w = '0;
    if (row < PROG_ROWS) begin
      case (row)
        4, 12, 20: w[63:56] = OP_TOGGLE;
        27: begin
          w[63:56] = OP_JUMP;
          w[15:0]  = 16'h0040;
        end
        5, 6, 7, 28, 29, 30, 31: w[63:56] = OP_NOP;
        default: begin
          w[63:56] = OP_ALU;
          w[15:0]  = 16'(row * 8);
        end
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/l1mm_ctrl.sv
module l1mm_ctrl
  import l1mm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWrEn,
  input  logic [1:0]  modeWrData,
  input  logic        coreReq,
  input  logic        lookupHit,
  input  logic        dbgWrEn,
  input  logic        fillValid,
  output ctrlStrobe_t strobe,
  output memMode_e    curMode,
  output logic        missPend
);

  memMode_e modeQ;
  logic     pendQ;
  logic     modeAccept;

  assign modeAccept = modeWrEn && (modeWrData != MODE_RSVD);

  always_comb begin
    strobe             = '0;
    strobe.rdEn        = coreReq && !pendQ && !modeAccept;
    strobe.forceHit    = (modeQ != MODE_CACHE);
    strobe.missCapture = strobe.rdEn && (modeQ == MODE_CACHE) && !lookupHit;
    strobe.fillWr      = fillValid && pendQ && !modeAccept;
    strobe.dbgWr       = dbgWrEn && (modeQ == MODE_SCRATCH);
    strobe.clearValid  = modeAccept;
    strobe.loadProg    = modeAccept && (modeWrData == MODE_SELFTEST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_SELFTEST;
      pendQ <= 1'b0;
    end else begin
      if (modeAccept) begin
        modeQ <= memMode_e'(modeWrData);
        pendQ <= 1'b0;
      end else if (strobe.missCapture) begin
        pendQ <= 1'b1;
      end else if (strobe.fillWr) begin
        pendQ <= 1'b0;
      end
    end
  end

  assign curMode  = modeQ;
  assign missPend = pendQ;

endmodule

// File: rtl/l1mm_dpath.sv
module l1mm_dpath
  import l1mm_pkg::*;
#(
  parameter int WORD_ADDR_W = 13,
  parameter int DATA_W      = 64,
  parameter int ROWS        = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic [WORD_ADDR_W-1:0]    coreAddr,
  input  logic [$clog2(ROWS)-1:0]   dbgRow,
  input  logic [DATA_W-1:0]         dbgWrData,
  input  logic [DATA_W-1:0]         fillData,
  output logic                      lookupHit,
  output logic                      coreValid,
  output logic                      coreHit,
  output logic [DATA_W-1:0]         coreRdata,
  output logic [WORD_ADDR_W-1:0]    missAddr
);

  localparam int IDX_W = $clog2(ROWS);
  localparam int TAG_W = WORD_ADDR_W - IDX_W;

  logic [DATA_W-1:0] dataArr [ROWS];
  logic [TAG_W-1:0]  tagArr  [ROWS];
  logic [ROWS-1:0]   validVec;

  logic [IDX_W-1:0]  rdIdx;
  logic [TAG_W-1:0]  rdTag;
  logic [IDX_W-1:0]  missIdxQ;
  logic [TAG_W-1:0]  missTagQ;
  logic              rdValidQ;
  logic              rdHitQ;
  logic [DATA_W-1:0] rdDataQ;

  assign rdIdx     = coreAddr[IDX_W-1:0];
  assign rdTag     = coreAddr[WORD_ADDR_W-1:IDX_W];
  assign lookupHit = validVec[rdIdx] && (tagArr[rdIdx] == rdTag);

  // Data array: reset and self-test entry load the program
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ROWS; i++) dataArr[i] <= DATA_W'(progWord(i));
    end else if (strobe.loadProg) begin
      for (int i = 0; i < ROWS; i++) dataArr[i] <= DATA_W'(progWord(i));
    end else begin
      if (strobe.fillWr) dataArr[missIdxQ] <= fillData;
      if (strobe.dbgWr && !(strobe.fillWr && dbgRow == missIdxQ))
        dataArr[dbgRow] <= dbgWrData;
    end
  end

  // Tags and valid bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
      for (int i = 0; i < ROWS; i++) tagArr[i] <= '0;
    end else if (strobe.clearValid) begin
      validVec <= '0;
    end else if (strobe.fillWr) begin
      validVec[missIdxQ] <= 1'b1;
      tagArr[missIdxQ]   <= missTagQ;
    end
  end

  // Miss address capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      missIdxQ <= '0;
      missTagQ <= '0;
    end else if (strobe.missCapture) begin
      missIdxQ <= rdIdx;
      missTagQ <= rdTag;
    end
  end

  // One-cycle read result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      rdHitQ   <= 1'b0;
      rdDataQ  <= '0;
    end else begin
      rdValidQ <= strobe.rdEn;
      if (strobe.rdEn) begin
        rdHitQ  <= strobe.forceHit || lookupHit;
        rdDataQ <= dataArr[rdIdx];
      end
    end
  end

  assign coreValid = rdValidQ;
  assign coreHit   = rdHitQ;
  assign coreRdata = rdDataQ;
  assign missAddr  = {missTagQ, missIdxQ};

endmodule

// File: rtl/l1_multimode_mem.sv
module l1_multimode_mem
  import l1mm_pkg::*;
#(
  parameter int WORD_ADDR_W = 13,
  parameter int DATA_W      = 64,
  parameter int ROWS        = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    modeWrEn,
  input  logic [1:0]              modeWrData,
  input  logic                    coreReq,
  input  logic [WORD_ADDR_W-1:0]  coreAddr,
  output logic                    coreValid,
  output logic                    coreHit,
  output logic [DATA_W-1:0]       coreRdata,
  input  logic                    dbgWrEn,
  input  logic [$clog2(ROWS)-1:0] dbgRow,
  input  logic [DATA_W-1:0]       dbgWrData,
  output logic                    missReq,
  output logic [WORD_ADDR_W-1:0]  missAddr,
  input  logic                    fillValid,
  input  logic [DATA_W-1:0]       fillData
);

  ctrlStrobe_t strobe;
  memMode_e    modeNow;
  logic [1:0]  curMode;
  logic        lookupHit;

  assign curMode = modeNow;

  l1mm_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeWrEn   (modeWrEn),
    .modeWrData (modeWrData),
    .coreReq    (coreReq),
    .lookupHit  (lookupHit),
    .dbgWrEn    (dbgWrEn),
    .fillValid  (fillValid),
    .strobe     (strobe),
    .curMode    (modeNow),
    .missPend   (missReq)
  );

  l1mm_dpath #(
    .WORD_ADDR_W (WORD_ADDR_W),
    .DATA_W      (DATA_W),
    .ROWS        (ROWS)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .coreAddr  (coreAddr),
    .dbgRow    (dbgRow),
    .dbgWrData (dbgWrData),
    .fillData  (fillData),
    .lookupHit (lookupHit),
    .coreValid (coreValid),
    .coreHit   (coreHit),
    .coreRdata (coreRdata),
    .missAddr  (missAddr)
  );

endmodule

// File: rtl/l1mm_checker.sv
module l1mm_checker #(
  parameter int WORD_ADDR_W = 13
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   modeWrEn,
  input logic [1:0]             modeWrData,
  input logic                   coreReq,
  input logic                   coreValid,
  input logic                   coreHit,
  input logic                   missReq,
  input logic [WORD_ADDR_W-1:0] missAddr,
  input logic                   fillValid,
  input logic [1:0]             curMode
);

  AST_RSVD_MODE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && modeWrData == 2'd3) |=> $stable(curMode)); // R3

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    coreValid |-> $past(coreReq)); // R4

  AST_FORCED_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (coreValid && $past(curMode) != 2'd0) |-> coreHit); // R4

  AST_MISS_RAISES_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (coreValid && !coreHit) |-> missReq); // R7

  AST_MISS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (missReq && !fillValid && !(modeWrEn && modeWrData != 2'd3)) |=> missReq); // R7

  AST_MISS_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (missReq && !fillValid) |=> (!missReq || $stable(missAddr))); // R7

  AST_MISS_ONLY_CACHE: assert property (@(posedge clk) disable iff (!rstN)
    missReq |-> curMode == 2'd0); // R7

  AST_FILL_CLOSES_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (missReq && fillValid) |=> !missReq); // R8

endmodule

bind l1_multimode_mem l1mm_checker #(.WORD_ADDR_W(WORD_ADDR_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeWrEn   (modeWrEn),
  .modeWrData (modeWrData),
  .coreReq    (coreReq),
  .coreValid  (coreValid),
  .coreHit    (coreHit),
  .missReq    (missReq),
  .missAddr   (missAddr),
  .fillValid  (fillValid),
  .curMode    (curMode)
);

// File: tb/test_l1_multimode_mem.sv
module test_l1_multimode_mem;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int DW = 64;
  localparam int NR = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modeWrEn = 1'b0;
  logic [1:0]    modeWrData = '0;
  logic          coreReq = 1'b0;
  logic [AW-1:0] coreAddr = '0;
  logic          coreValid, coreHit;
  logic [DW-1:0] coreRdata;
  logic          dbgWrEn = 1'b0;
  logic [4:0]    dbgRow = '0;
  logic [DW-1:0] dbgWrData = '0;
  logic          missReq;
  logic [AW-1:0] missAddr;
  logic          fillValid = 1'b0;
  logic [DW-1:0] fillData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l1_multimode_mem i_l1_multimode_mem (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .coreReq(coreReq), .coreAddr(coreAddr), .coreValid(coreValid),
    .coreHit(coreHit), .coreRdata(coreRdata), .dbgWrEn(dbgWrEn),
    .dbgRow(dbgRow), .dbgWrData(dbgWrData), .missReq(missReq),
    .missAddr(missAddr), .fillValid(fillValid), .fillData(fillData)
  );

  // Reference model
  logic [DW-1:0] mArr [NR];
  bit            mValid [NR];
  logic [7:0]    mTag [NR];
  int            mMode;
  bit            mPend;
  logic [AW-1:0] mMissAddr;
  int            nRun = 0;
  int            nFail = 0;

  function automatic logic [63:0] expProg(input int row);
    logic [63:0] w = '0;
    if (row == 4 || row == 12 || row == 20) w[63:56] = 8'h7E;
    else if (row == 27) begin w[63:56] = 8'h6A; w[15:0] = 16'h0040; end
    else if ((row >= 5 && row <= 7) || row >= 28) w = '0;
    else begin w[63:56] = 8'h11; w[15:0] = 16'(row * 8); end
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NR; i++) begin
      mArr[i] = expProg(i); mValid[i] = 0; mTag[i] = '0;
    end
    mMode = 2; mPend = 0;
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk); modeWrEn = 1'b1; modeWrData = m;
    @(negedge clk); modeWrEn = 1'b0;
    if (m != 2'd3) begin
      mMode = m; mPend = 0;
      for (int i = 0; i < NR; i++) begin
        mValid[i] = 0;
        if (m == 2'd2) mArr[i] = expProg(i);
      end
      chk(missReq == 1'b0, "R9 miss cancelled", 64'(missReq), 64'd0);
    end
  endtask

  task automatic dbgWrite(input logic [4:0] r, input logic [DW-1:0] d);
    @(negedge clk); dbgWrEn = 1'b1; dbgRow = r; dbgWrData = d;
    @(negedge clk); dbgWrEn = 1'b0;
    if (mMode == 1) mArr[r] = d;
  endtask

  task automatic coreRead(input logic [AW-1:0] a, input string req);
    int  row;
    bit  hit;
    row = int'(a[4:0]);
    @(negedge clk); coreReq = 1'b1; coreAddr = a;
    @(negedge clk); coreReq = 1'b0;
    if (mPend) begin
      chk(coreValid == 1'b0, {req, " R7 read blocked"}, 64'(coreValid), 64'd0);
      return;
    end
    chk(coreValid == 1'b1, {req, " R4 valid"}, 64'(coreValid), 64'd1);
    if (mMode != 0) begin
      chk(coreHit == 1'b1, {req, " R4 forced hit"}, 64'(coreHit), 64'd1);
      chk(coreRdata == mArr[row], {req, " data"}, coreRdata, mArr[row]);
    end else begin
      hit = mValid[row] && (mTag[row] == a[12:5]);
      chk(coreHit == hit, {req, " R6 hit"}, 64'(coreHit), 64'(hit));
      if (hit) chk(coreRdata == mArr[row], {req, " R6 data"}, coreRdata, mArr[row]);
      else begin
        chk(missReq == 1'b1, {req, " R7 missReq"}, 64'(missReq), 64'd1);
        chk(missAddr == a, {req, " R7 missAddr"}, 64'(missAddr), 64'(a));
        mPend = 1; mMissAddr = a;
      end
    end
  endtask

  task automatic fill(input logic [DW-1:0] d);
    @(negedge clk); fillValid = 1'b1; fillData = d;
    @(negedge clk); fillValid = 1'b0;
    chk(missReq == 1'b0, "R8 missReq falls", 64'(missReq), 64'd0);
    if (mPend) begin
      mArr[mMissAddr[4:0]] = d; mValid[mMissAddr[4:0]] = 1;
      mTag[mMissAddr[4:0]] = mMissAddr[12:5]; mPend = 0;
    end
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(coreValid == 1'b0, "R1 coreValid", 64'(coreValid), 64'd0);
    chk(missReq == 1'b0, "R1 missReq", 64'(missReq), 64'd0);
    rstN = 1'b1;
    // R1/R2: program preloaded
    for (int r = 0; r < NR; r++) coreRead(AW'(r), "R2 program");
    // R3: reserved code ignored, still self-test
    setMode(2'd3);
    coreRead(13'h0004, "R3 reserved ignored");
    // R5: debug write ignored in self-test
    dbgWrite(5'd9, 64'hDEAD_BEEF_0000_0001);
    coreRead(13'h0009, "R5 dbg ignored selftest");
    // R5: scratchpad write and tag-blind read
    setMode(2'd1);
    dbgWrite(5'd7, 64'h0123_4567_89AB_CDEF);
    coreRead(13'h0007, "R5 scratch read");
    coreRead(13'h1FE7, "R5 scratch tag ignored");
    // R10: self-test entry reloads program
    setMode(2'd2);
    coreRead(13'h0007, "R10 reload");
    // Cache mode: miss, blocked read, fill, hit
    setMode(2'd0);
    coreRead(13'h0247, "R6 cold miss");
    coreRead(13'h0003, "R7 while pending");
    fill(64'hCAFE_F00D_1111_2222);
    coreRead(13'h0247, "R8 hit after fill");
    coreRead(13'h0347, "R6 conflict miss");
    fill(64'h5555_AAAA_5555_AAAA);
    coreRead(13'h0347, "R8 refill hit");
    // R5: debug write ignored in cache mode
    dbgWrite(5'd7, 64'h0);
    coreRead(13'h0347, "R5 dbg ignored cache");
    // R9: mode write cancels miss and clears valids
    coreRead(13'h0011, "R9 setup miss");
    setMode(2'd0);
    coreRead(13'h0347, "R9 cleared");
    fill(64'h7777_0000_7777_0000);
    // R11: spurious fill
    fill(64'hFFFF_FFFF_FFFF_FFFF);
    coreRead(13'h0011, "R11 spurious fill");
    if (mPend) fill(64'h1);

    // Constrained random phase
    void'($urandom(32'd20240611));
    for (int it = 0; it < 600; it++) begin
      int sel;
      logic [AW-1:0] a;
      sel = int'($urandom_range(0, 99));
      a = {3'b000, 2'($urandom_range(0, 3)), 3'b000, 5'($urandom_range(0, 31))};
      d = {$urandom, $urandom};
      if (mPend && sel < 60) fill(d);
      else if (sel < 75) coreRead(a, "R6 random read");
      else if (sel < 85) dbgWrite(5'($urandom_range(0, 31)), d);
      else if (sel < 90) fill(d);
      else setMode(2'($urandom_range(0, 3)));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule